// File: doc/BRIEF.md
# T1 Data-Multiplexer Sync Byte Inserter and Checker

This block handles the sync byte that the T1 data-multiplexer format places in the last channel of every 193-bit T1 frame. The frame is one framing bit followed by 24 eight-bit channels. The sync byte is sent as 1, 0, 1, 1, 1, Y, R, 0 in transmission order. Y carries the yellow-alarm indication. R carries an 8 kb/s data link at one bit per frame.

On the transmit side the block overwrites the sync channel with this pattern and takes Y and R from two inputs. On the receive side it takes Y and R out of the sync channel. It also reports, once per frame, whether the six fixed bits arrived as expected. Y and R are left out of that comparison.

Both directions are bit-serial and share one clock enable that marks each bit time. Each direction has its own frame-start marker on the framing bit. Searching for the framing-bit pattern and deciding when to reframe happen outside this block.

Top module: `t1dm_sync_byte`

## Requirements
- R1: After reset, tx_bit_o, rx_match_o, rx_yel_o, rx_rdl_o and rx_valid_o are all 0.
- R2: A frame-start marker taken with bit_en_i marks frame position 0. Without a new marker, the position counts up and wraps from 192 to 0. Bits that arrive before the first marker of a direction pass through that direction unaltered and are not checked.
- R3: With mode_en_i high, transmit positions 185 to 192 are replaced by the bits 1,0,1,1,1,Y,R,0 in that order. Y is yel_i and R is rdl_i, each sampled during its own bit time (positions 190 and 191).
- R4: tx_bit_o is a register loaded on every clock with bit_en_i high. Outside positions 185 to 192, including the framing bit at position 0, it takes the value of tx_bit_i from that bit time.
- R5: With mode_en_i low, positions 185 to 192 also pass from tx_bit_i to tx_bit_o unaltered.
- R6: On the clock that takes receive position 192 with mode_en_i high, rx_match_o is loaded with 1 when received positions 185 to 189 and 192 equal 1,0,1,1,1,0, and with 0 otherwise. The bits at positions 190 and 191 have no effect on it.
- R7: On that same clock, rx_yel_o and rx_rdl_o are loaded with the bits received at positions 190 and 191. rx_valid_o is high for exactly the one clock that follows.
- R8: Outside that update, rx_match_o, rx_yel_o and rx_rdl_o hold their values. No update happens for a frame whose position 192 arrives with mode_en_i low.
- R9: While bit_en_i is low, no position advances and all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One bit time on both directions when high |
| mode_en_i | input | 1 | Enables sync byte insertion and checking |
| tx_sof_i | input | 1 | Transmit framing-bit marker |
| tx_bit_i | input | 1 | Transmit serial data in |
| yel_i | input | 1 | Yellow-alarm bit to send |
| rdl_i | input | 1 | Data-link bit to send |
| tx_bit_o | output | 1 | Transmit serial data out, registered |
| rx_sof_i | input | 1 | Receive framing-bit marker |
| rx_bit_i | input | 1 | Receive serial data in |
| rx_match_o | output | 1 | Fixed sync bits matched in the last checked frame |
| rx_yel_o | output | 1 | Yellow-alarm bit received |
| rx_rdl_o | output | 1 | Data-link bit received |
| rx_valid_o | output | 1 | One-clock pulse when the receive outputs update |

## Verification
The bench flips only the Y and R positions of the received byte to show that the match flag ignores them. A checker that compared all eight bits would report a false mismatch. It also corrupts the first and the last fixed bit separately, which catches an accumulator that is reset too late or sampled before its final bit. Frames sent with no start marker test the wrap from 192 to 0: an off-by-one counter would move the inserted byte into the framing bit or into channel 23. Idle gaps in the middle of a frame, and a frame sent with the mode off, check that nothing advances without the enable and that the sync channel then passes through untouched.

// File: rtl/t1dm_pkg.sv
`timescale 1ns/1ps
package t1dm_pkg;
  localparam int CH_BITS = 8;
  // bit k = k-th transmitted bit of the sync channel
  localparam logic [CH_BITS-1:0] SYNC_FIX = 8'b0001_1101;
  localparam logic [CH_BITS-1:0] SYNC_VAR = 8'b0110_0000;
  localparam int Y_IDX = 5;
  localparam int R_IDX = 6;

  function automatic int slot_first(input int sync_ch);
    return 1 + (sync_ch - 1) * CH_BITS;
  endfunction
endpackage

// File: rtl/t1dm_frame_ctr.sv
`timescale 1ns/1ps
module t1dm_frame_ctr #(
  parameter int FRAME_BITS = 193,
  parameter int POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             sof_i,
  output logic [POS_W-1:0] pos_o,
  output logic             locked_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] pos_q;
  logic             locked_q;

  // position of the bit presented this cycle
  always_comb begin
    if (sof_i)              pos_o = '0;
    else if (pos_q == LAST) pos_o = '0;
    else                    pos_o = pos_q + 1'b1;
  end
  assign locked_o = locked_q | sof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= LAST;
      locked_q <= 1'b0;
    end else if (bit_en_i) begin
      pos_q    <= pos_o;
      locked_q <= locked_o;
    end
  end

  p_pos_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= LAST);
  p_sof_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && sof_i) |=> (pos_q == '0));
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(pos_q));
endmodule

// File: rtl/t1dm_slot_dec.sv
`timescale 1ns/1ps
module t1dm_slot_dec
  import t1dm_pkg::*;
#(
  parameter int POS_W      = 8,
  parameter int SLOT_FIRST = 185
) (
  input  logic [POS_W-1:0]   pos_i,
  output logic [CH_BITS-1:0] hit_o
);
  for (genvar g = 0; g < CH_BITS; g++) begin : g_hit
    localparam logic [POS_W-1:0] P = POS_W'(SLOT_FIRST + g);
    assign hit_o[g] = (pos_i == P);
  end
endmodule

// File: rtl/t1dm_tx_insert.sv
`timescale 1ns/1ps
module t1dm_tx_insert
  import t1dm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               mode_en_i,
  input  logic               locked_i,
  input  logic [CH_BITS-1:0] hit_i,
  input  logic               bit_i,
  input  logic               yel_i,
  input  logic               rdl_i,
  output logic               bit_o
);
  logic [CH_BITS-1:0] slot_bits;
  logic               ins, ins_bit;

  for (genvar g = 0; g < CH_BITS; g++) begin : g_pat
    if (g == Y_IDX)      begin : g_y assign slot_bits[g] = yel_i;       end
    else if (g == R_IDX) begin : g_r assign slot_bits[g] = rdl_i;       end
    else                 begin : g_f assign slot_bits[g] = SYNC_FIX[g]; end
  end

  assign ins     = mode_en_i & locked_i & (|hit_i);
  assign ins_bit = |(hit_i & slot_bits);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bit_o <= 1'b0;
    else if (bit_en_i) bit_o <= ins ? ins_bit : bit_i;
  end

  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(bit_o));
  p_tx_sync_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && mode_en_i && locked_i && hit_i[0]) |=> bit_o);
endmodule

// File: rtl/t1dm_rx_check.sv
`timescale 1ns/1ps
module t1dm_rx_check
  import t1dm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_en_i,
  input  logic               mode_en_i,
  input  logic               locked_i,
  input  logic [CH_BITS-1:0] hit_i,
  input  logic               bit_i,
  output logic               match_o,
  output logic               yel_o,
  output logic               rdl_o,
  output logic               valid_o
);
  logic act, fixed_pos, exp_bit, mis, err_n;
  logic err_q, y_q, r_q;

  assign act       = bit_en_i & mode_en_i & locked_i;
  assign fixed_pos = |(hit_i & ~SYNC_VAR);
  assign exp_bit   = |(hit_i & SYNC_FIX);
  assign mis       = fixed_pos & (bit_i ^ exp_bit);
  assign err_n     = hit_i[0] ? mis : (err_q | mis);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      y_q     <= 1'b0;
      r_q     <= 1'b0;
      match_o <= 1'b0;
      yel_o   <= 1'b0;
      rdl_o   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (act && (|hit_i)) begin
        err_q <= err_n;
        if (hit_i[Y_IDX]) y_q <= bit_i;
        if (hit_i[R_IDX]) r_q <= bit_i;
        if (hit_i[CH_BITS-1]) begin
          match_o <= ~err_n;
          yel_o   <= y_q;
          rdl_o   <= r_q;
          valid_o <= 1'b1;
        end
      end
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable({match_o, yel_o, rdl_o}));
  p_no_update_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en_i |=> !valid_o);
endmodule

// File: rtl/t1dm_sync_byte.sv
`timescale 1ns/1ps
module t1dm_sync_byte
  import t1dm_pkg::*;
#(
  parameter int N_CH    = 24,
  parameter int SYNC_CH = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic mode_en_i,
  input  logic tx_sof_i,
  input  logic tx_bit_i,
  input  logic yel_i,
  input  logic rdl_i,
  output logic tx_bit_o,
  input  logic rx_sof_i,
  input  logic rx_bit_i,
  output logic rx_match_o,
  output logic rx_yel_o,
  output logic rx_rdl_o,
  output logic rx_valid_o
);
  localparam int FRAME_BITS = 1 + N_CH * CH_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int SLOT_FIRST = slot_first(SYNC_CH);

  logic [POS_W-1:0]   tx_pos, rx_pos;
  logic               tx_lock, rx_lock;
  logic [CH_BITS-1:0] tx_hit, rx_hit;

  t1dm_frame_ctr #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_tx_ctr (
    .clk_i, .rst_ni, .bit_en_i, .sof_i(tx_sof_i),
    .pos_o(tx_pos), .locked_o(tx_lock));

  t1dm_frame_ctr #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_rx_ctr (
    .clk_i, .rst_ni, .bit_en_i, .sof_i(rx_sof_i),
    .pos_o(rx_pos), .locked_o(rx_lock));

  t1dm_slot_dec #(.POS_W(POS_W), .SLOT_FIRST(SLOT_FIRST)) u_tx_dec (
    .pos_i(tx_pos), .hit_o(tx_hit));

  t1dm_slot_dec #(.POS_W(POS_W), .SLOT_FIRST(SLOT_FIRST)) u_rx_dec (
    .pos_i(rx_pos), .hit_o(rx_hit));

  t1dm_tx_insert u_tx (
    .clk_i, .rst_ni, .bit_en_i, .mode_en_i, .locked_i(tx_lock),
    .hit_i(tx_hit), .bit_i(tx_bit_i), .yel_i, .rdl_i, .bit_o(tx_bit_o));

  t1dm_rx_check u_rx (
    .clk_i, .rst_ni, .bit_en_i, .mode_en_i, .locked_i(rx_lock),
    .hit_i(rx_hit), .bit_i(rx_bit_i), .match_o(rx_match_o),
    .yel_o(rx_yel_o), .rdl_o(rx_rdl_o), .valid_o(rx_valid_o));

  p_fbit_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && tx_sof_i) |=> (tx_bit_o == $past(tx_bit_i)));
  p_pass_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !mode_en_i) |=> (tx_bit_o == $past(tx_bit_i)));
  p_hit_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_hit) && $onehot0(rx_hit));
endmodule

// File: tb/sim_t1dm_sync_byte.sv
`timescale 1ns/1ps
module sim_t1dm_sync_byte;
  typedef struct packed {
    logic tx;
    logic vld;
    logic m;
    logic y;
    logic r;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bit_en = 0, mode_en = 0, tx_sof = 0, tx_bit = 0, yel = 0, rdl = 0;
  logic rx_sof = 0, rx_bit = 0;
  logic tx_bit_o, rx_match_o, rx_yel_o, rx_rdl_o, rx_valid_o;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t  exp_q[$];
  string ttag_q[$];
  string rtag_q[$];

  // bench model
  int   m_pos = 192;
  bit   m_lock = 0;
  logic m_err = 0, m_yc = 0, m_rc = 0, m_match = 0, m_yel = 0, m_rdl = 0, m_tx = 0;

  always #4 clk = ~clk;

  t1dm_sync_byte u0 (
    .clk_i(clk), .rst_ni, .bit_en_i(bit_en), .mode_en_i(mode_en),
    .tx_sof_i(tx_sof), .tx_bit_i(tx_bit), .yel_i(yel), .rdl_i(rdl),
    .tx_bit_o, .rx_sof_i(rx_sof), .rx_bit_i(rx_bit),
    .rx_match_o, .rx_yel_o, .rx_rdl_o, .rx_valid_o);

  function automatic logic pat_bit(int k, logic y, logic r);
    case (k)
      0, 2, 3, 4: return 1'b1;
      5: return y;
      6: return r;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] rx_byte(logic y, logic r, logic [7:0] flip);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[k] = pat_bit(k, y, r);
    return b ^ flip;
  endfunction

  task automatic drive_bit(input logic sof, input logic tin, input logic rin);
    int pos, k;
    bit in_slot;
    exp_t e;
    string tt, rt;
    @(negedge clk);
    bit_en = 1; tx_sof = sof; rx_sof = sof; tx_bit = tin; rx_bit = rin;
    pos = sof ? 0 : (m_pos == 192 ? 0 : m_pos + 1);
    m_lock = m_lock | sof;
    m_pos = pos;
    k = pos - 185;
    in_slot = m_lock && pos >= 185;
    e.vld = 0;
    if (in_slot && mode_en) begin
      m_tx = pat_bit(k, yel, rdl); tt = "R3";
      if (k == 0) m_err = 0;
      if (k != 5 && k != 6 && rin != pat_bit(k, 0, 0)) m_err = 1;
      if (k == 5) m_yc = rin;
      if (k == 6) m_rc = rin;
      if (k == 7) begin
        m_match = !m_err; m_yel = m_yc; m_rdl = m_rc; e.vld = 1;
      end
    end else begin
      m_tx = tin;
      tt = !m_lock ? "R2" : (in_slot ? "R5" : "R4");
    end
    rt = e.vld ? "R6/R7" : "R8";
    e.tx = m_tx; e.m = m_match; e.y = m_yel; e.r = m_rdl;
    @(posedge clk); #1;
    exp_q.push_back(e); ttag_q.push_back(tt); rtag_q.push_back(rt);
  endtask

  task automatic idle(input int n);
    exp_t e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 0; tx_bit = ~tx_bit; rx_bit = ~rx_bit; tx_sof = 1; rx_sof = 1;
      e.tx = m_tx; e.vld = 0; e.m = m_match; e.y = m_yel; e.r = m_rdl;
      @(posedge clk); #1;
      exp_q.push_back(e); ttag_q.push_back("R9"); rtag_q.push_back("R9");
    end
    @(negedge clk); tx_sof = 0; rx_sof = 0;
  endtask

  task automatic send_frame(input bit use_sof, input logic y, input logic r,
                            input logic [7:0] rxb, input bit gap);
    for (int p = 0; p < 193; p++) begin
      if (p == 0) begin yel = y; rdl = r; end
      if (gap && p == 100) idle(3);
      drive_bit(use_sof && p == 0, 1'($urandom),
                p >= 185 ? rxb[p-185] : 1'($urandom));
    end
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    string tt, rt;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front(); tt = ttag_q.pop_front(); rt = rtag_q.pop_front();
        checks++;
        if (tx_bit_o !== e.tx) begin
          errors++;
          $display("FAIL %s tx_bit_o act=%b exp=%b pos=%0d", tt, tx_bit_o, e.tx, m_pos);
        end
        checks++;
        if ({rx_valid_o, rx_match_o, rx_yel_o, rx_rdl_o} !== {e.vld, e.m, e.y, e.r}) begin
          errors++;
          $display("FAIL %s rx v/m/y/r act=%b%b%b%b exp=%b%b%b%b", rt,
                   rx_valid_o, rx_match_o, rx_yel_o, rx_rdl_o, e.vld, e.m, e.y, e.r);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if ({tx_bit_o, rx_match_o, rx_yel_o, rx_rdl_o, rx_valid_o} !== 5'b0) begin
      errors++;
      $display("FAIL R1 reset outputs act=%b exp=00000",
               {tx_bit_o, rx_match_o, rx_yel_o, rx_rdl_o, rx_valid_o});
    end
    rst_ni = 1;
    mode_en = 1;
    // R2: no marker yet, pass-through
    for (int i = 0; i < 20; i++) drive_bit(0, 1'($urandom), 1'($urandom));
    send_frame(1, 0, 0, rx_byte(0, 0, 8'h00), 0);  // R3/R6 clean
    send_frame(1, 1, 1, rx_byte(1, 1, 8'h00), 0);  // R7 Y=R=1
    send_frame(1, 1, 0, rx_byte(0, 1, 8'h00), 0);  // R6 Y/R differ, still match
    send_frame(1, 0, 1, rx_byte(0, 0, 8'h01), 0);  // R6 first fixed bit bad
    send_frame(1, 0, 0, rx_byte(1, 0, 8'h80), 0);  // R6 last fixed bit bad
    send_frame(0, 1, 0, rx_byte(1, 1, 8'h00), 0);  // R2 wrap without marker
    send_frame(1, 0, 1, rx_byte(0, 1, 8'h04), 1);  // R9 idle gap
    mode_en = 0;
    send_frame(1, 1, 1, rx_byte(0, 0, 8'h00), 0);  // R5/R8 mode off
    mode_en = 1;
    send_frame(1, 1, 1, rx_byte(1, 0, 8'h00), 1);
    idle(2);
    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule